// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects interrupt requests from one raster source and three DMA channels and presents them to a Z80-style CPU that runs in interrupt mode 2. Each request arrives as a one-cycle pulse and sets a pending flag. While any flag is set, the block holds a single active-low interrupt request line low. When the CPU runs an acknowledge cycle, shown by M1 and IORQ both low, the block places an 8-bit vector on the data bus. The vector joins a software-programmed upper field with a 2-bit code for the winning source.

The raster request is formed from two inputs: a fixed periodic interrupt that fires every 52 lines and a programmable line-match interrupt. Acknowledging the raster source always clears its flag and sets a record bit. A mode bit in the vector register selects how DMA flags behave on acknowledge: either the acknowledge clears them, or they stay set until software clears them. An acknowledge that finds nothing pending still returns a vector, the one for the lowest-priority DMA channel. A CPU that issues two acknowledges in a row therefore gets the raster vector and then the DMA channel 0 vector.

Top module: `irq_vector_ctrl`

## Requirements
- R1: During an acknowledge, vector bit 0 is 0 and vector bits 7..3 equal bits 7..3 of the vector register, which software writes and reads at register offset 5.
- R2: Vector bits 2..1 identify the source, giving a vector low part of 6 for raster, 4 for DMA channel 0, 2 for DMA channel 1 and 0 for DMA channel 2.
- R3: When several flags are pending, the acknowledged source is the highest in the order raster, DMA 2, DMA 1, DMA 0.
- R4: A pulse on either the periodic-line input or the line-match input sets the raster pending flag (status bit 3).
- R5: A pulse on DMA input n sets status bit n. int_n is low in the cycle after any flag is set, and stays low while any pending flag is set. It is high when none is set.
- R6: After reset the vector register reads 0x01, the status register (offset 4) reads 0x00 and int_n is high.
- R7: With vector register bit 0 at 0, acknowledging a DMA source clears that channel's pending flag.
- R8: With vector register bit 0 at 1, acknowledging a DMA source leaves its flag set. Repeated acknowledges return the same vector.
- R9: Acknowledging the raster source clears status bit 3 and sets the record flag, status bit 7.
- R10: An acknowledge with no flag pending returns the DMA channel 0 vector (low part 4) and changes no state. A second acknowledge right after a lone raster acknowledge returns that vector.
- R11: Writing the status register clears each flag (bits 3..0 and 7) whose written bit is 1. Bits written as 0 have no effect. A request pulse in the same cycle as its clear leaves the flag set.
- R12: The vector is driven (vec_oe_o high) only while M1 and IORQ are both low. Otherwise vec_data_o is 0. The vector is captured in the first acknowledge cycle and held unchanged until the acknowledge ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line52_irq_i | input | 1 | Periodic 52-line raster pulse |
| line_match_irq_i | input | 1 | Programmable line-match raster pulse |
| dma_irq_i | input | 3 | DMA channel interrupt pulses, bit n for channel n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register write offset (4 status, 5 vector) |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdaddr_i | input | 4 | Register read offset |
| reg_rdata_o | output | 8 | Register read data, combinational |
| m1_n_i | input | 1 | CPU M1, active low |
| iorq_n_i | input | 1 | CPU IORQ, active low |
| vec_data_o | output | 8 | Vector placed on the data bus |
| vec_oe_o | output | 1 | Data bus drive enable for the vector |
| int_n_o | output | 1 | Interrupt request to the CPU, active low |

## Verification
The hardest case to reach from the ports is the double acknowledge. A raster acknowledge clears the only pending flag, and a second acknowledge then follows at once and must fall back to the DMA channel 0 vector. The bench builds this directly: it pulses only the raster source and issues two acknowledges separated by a single idle cycle. Hold mode with stacked DMA flags, and a request pulse in the same cycle as its own clear, are also set up as directed cases. Random runs then mix pulses, writes and acknowledges in both auto-clear and hold modes.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
   localparam int CODE_W = 2;

   typedef enum logic [CODE_W-1:0] {
      SRC_DMA2   = 2'd0,
      SRC_DMA1   = 2'd1,
      SRC_DMA0   = 2'd2,
      SRC_RASTER = 2'd3
   } src_code_e;

   // code for DMA channel idx: highest channel gets the smallest code
   function automatic logic [CODE_W-1:0] dma_code(input int idx, input int num_dma);
      return CODE_W'(num_dma - 1 - idx);
   endfunction
endpackage

// File: rtl/irq_pending.sv
module irq_pending #(
   parameter int N_SRC = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] set_i,
   input  logic [N_SRC-1:0] clr_i,
   output logic [N_SRC-1:0] pend_o
);
   for (genvar i = 0; i < N_SRC; i++) begin : g_flag
      always_ff @(posedge clk) begin
         if (!rst_n)        pend_o[i] <= 1'b0;
         else if (set_i[i]) pend_o[i] <= 1'b1;
         else if (clr_i[i]) pend_o[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irq_prio.sv
module irq_prio
   import irq_vector_pkg::*;
#(
   parameter int NUM_DMA = 3
) (
   input  logic [NUM_DMA-1:0] dma_pend_i,
   input  logic               raster_pend_i,
   output logic [NUM_DMA-1:0] dma_grant_o,
   output logic [CODE_W-1:0]  code_o
);
   // one-hot grant: a channel wins if no higher channel and no raster pending
   for (genvar i = 0; i < NUM_DMA; i++) begin : g_grant
      if (i == NUM_DMA - 1) begin : g_top
         assign dma_grant_o[i] = dma_pend_i[i] & ~raster_pend_i;
      end else begin : g_low
         assign dma_grant_o[i] = dma_pend_i[i] & ~raster_pend_i
                                 & ~(|dma_pend_i[NUM_DMA-1:i+1]);
      end
   end

   always_comb begin
      code_o = dma_code(0, NUM_DMA);   // empty fallback: lowest DMA channel
      for (int i = 0; i < NUM_DMA; i++) begin
         if (dma_grant_o[i]) code_o = dma_code(i, NUM_DMA);
      end
      if (raster_pend_i) code_o = SRC_RASTER;
   end
endmodule

// File: rtl/irq_ack_unit.sv
module irq_ack_unit #(
   parameter int VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             m1_n_i,
   input  logic             iorq_n_i,
   input  logic [VEC_W-1:0] vec_live_i,
   output logic             ack_start_o,
   output logic [VEC_W-1:0] vec_data_o,
   output logic             vec_oe_o
);
   logic             ack_now;
   logic             ack_q;
   logic [VEC_W-1:0] vec_q;

   assign ack_now     = ~m1_n_i & ~iorq_n_i;
   assign ack_start_o = ack_now & ~ack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_q <= 1'b0;
         vec_q <= '0;
      end else begin
         ack_q <= ack_now;
         if (ack_start_o) vec_q <= vec_live_i;
      end
   end

   assign vec_oe_o   = ack_now;
   assign vec_data_o = !ack_now ? '0 : (ack_q ? vec_q : vec_live_i);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vector_pkg::*;
#(
   parameter int NUM_DMA   = 3,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 4,
   parameter int STAT_ADDR = 4,
   parameter int VREG_ADDR = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               line52_irq_i,
   input  logic               line_match_irq_i,
   input  logic [NUM_DMA-1:0] dma_irq_i,
   input  logic               reg_wr_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   input  logic [ADDR_W-1:0]  reg_rdaddr_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   input  logic               m1_n_i,
   input  logic               iorq_n_i,
   output logic [DATA_W-1:0]  vec_data_o,
   output logic               vec_oe_o,
   output logic               int_n_o
);
   localparam int N_SRC    = NUM_DMA + 1;
   localparam int RAS_BIT  = NUM_DMA;
   localparam int REC_BIT  = DATA_W - 1;
   localparam int BASE_LSB = CODE_W + 1;
   localparam logic [DATA_W-1:0] VREG_RST = DATA_W'(1);

   if (N_SRC > (1 << CODE_W)) begin : g_chk_src
      $error("irq_vector_ctrl: too many sources for the code field");
   end
   if (DATA_W <= BASE_LSB || REC_BIT <= RAS_BIT) begin : g_chk_w
      $error("irq_vector_ctrl: data width too small");
   end
   if (STAT_ADDR == VREG_ADDR || VREG_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W)) begin : g_chk_a
      $error("irq_vector_ctrl: bad register offsets");
   end

   logic [DATA_W-1:0]  vec_reg_q;
   logic               rec_q;
   logic [N_SRC-1:0]   pend_q;
   logic [N_SRC-1:0]   set_src;
   logic [N_SRC-1:0]   clr_src;
   logic [NUM_DMA-1:0] dma_grant;
   logic [CODE_W-1:0]  code;
   logic [DATA_W-1:0]  vec_live;
   logic               ack_start;
   logic               stat_wr;
   logic               vreg_wr;
   logic               raster_in;
   logic               hold_mode;

   assign raster_in = line52_irq_i | line_match_irq_i;
   assign stat_wr   = reg_wr_i && (reg_addr_i == ADDR_W'(STAT_ADDR));
   assign vreg_wr   = reg_wr_i && (reg_addr_i == ADDR_W'(VREG_ADDR));
   assign hold_mode = vec_reg_q[0];

   assign set_src = {raster_in, dma_irq_i};

   for (genvar i = 0; i < NUM_DMA; i++) begin : g_dma_clr
      assign clr_src[i] = (stat_wr & reg_wdata_i[i])
                          | (ack_start & dma_grant[i] & ~hold_mode);
   end
   assign clr_src[RAS_BIT] = (stat_wr & reg_wdata_i[RAS_BIT])
                             | (ack_start & pend_q[RAS_BIT]);

   irq_pending #(.N_SRC(N_SRC)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_src),
      .clr_i  (clr_src),
      .pend_o (pend_q)
   );

   irq_prio #(.NUM_DMA(NUM_DMA)) u_prio (
      .dma_pend_i    (pend_q[NUM_DMA-1:0]),
      .raster_pend_i (pend_q[RAS_BIT]),
      .dma_grant_o   (dma_grant),
      .code_o        (code)
   );

   assign vec_live = {vec_reg_q[DATA_W-1:BASE_LSB], code, 1'b0};

   irq_ack_unit #(.VEC_W(DATA_W)) u_ack (
      .clk         (clk),
      .rst_n       (rst_n),
      .m1_n_i      (m1_n_i),
      .iorq_n_i    (iorq_n_i),
      .vec_live_i  (vec_live),
      .ack_start_o (ack_start),
      .vec_data_o  (vec_data_o),
      .vec_oe_o    (vec_oe_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_reg_q <= VREG_RST;
         rec_q     <= 1'b0;
      end else begin
         if (vreg_wr) vec_reg_q <= reg_wdata_i;
         if (ack_start && pend_q[RAS_BIT])        rec_q <= 1'b1;
         else if (stat_wr && reg_wdata_i[REC_BIT]) rec_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      if (reg_rdaddr_i == ADDR_W'(STAT_ADDR)) begin
         reg_rdata_o[N_SRC-1:0] = pend_q;
         reg_rdata_o[REC_BIT]   = rec_q;
      end else if (reg_rdaddr_i == ADDR_W'(VREG_ADDR)) begin
         reg_rdata_o = vec_reg_q;
      end
   end

   assign int_n_o = ~(|pend_q);
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
   parameter int NUM_DMA = 3,
   parameter int DATA_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m1_n,
   input logic              iorq_n,
   input logic              raster_in,
   input logic              ack_start,
   input logic [NUM_DMA:0]  pend,
   input logic [DATA_W-1:0] vreg,
   input logic [DATA_W-1:0] data_out,
   input logic              data_oe,
   input logic              int_n
);
   AST_VEC_LSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> !data_out[0]); // R1
   AST_VEC_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_start |-> data_out[DATA_W-1:3] == vreg[DATA_W-1:3]); // R1
   AST_BUS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!m1_n && !iorq_n) |-> (!data_oe && data_out == '0)); // R12
   AST_VEC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && !ack_start) |-> $stable(data_out)); // R12
   AST_RASTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      raster_in |=> !int_n); // R4
   AST_RASTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_start && pend[NUM_DMA] && !raster_in) |=> !pend[NUM_DMA]); // R9
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NUM_DMA(NUM_DMA), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .m1_n      (m1_n_i),
   .iorq_n    (iorq_n_i),
   .raster_in (raster_in),
   .ack_start (ack_start),
   .pend      (pend_q),
   .vreg      (vec_reg_q),
   .data_out  (vec_data_o),
   .data_oe   (vec_oe_o),
   .int_n     (int_n_o)
);

// File: tb/irq_vector_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_vector_ctrl_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       l52 = 1'b0, lmatch = 1'b0;
   logic [2:0] dma = '0;
   logic       wr = 1'b0;
   logic [3:0] waddr = '0, raddr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, vdata;
   logic       m1_n = 1'b1, iorq_n = 1'b1, voe, int_n;

   int errors = 0, checks = 0;
   logic [3:0] m_pend = '0;
   logic       m_rec = 1'b0;
   logic [7:0] m_vreg = 8'h01;

   always #5 clk = ~clk;

   irq_vector_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .line52_irq_i(l52), .line_match_irq_i(lmatch),
      .dma_irq_i(dma), .reg_wr_i(wr), .reg_addr_i(waddr), .reg_wdata_i(wdata),
      .reg_rdaddr_i(raddr), .reg_rdata_o(rdata), .m1_n_i(m1_n), .iorq_n_i(iorq_n),
      .vec_data_o(vdata), .vec_oe_o(voe), .int_n_o(int_n)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_vec(input logic [3:0] p, input logic [7:0] v);
      logic [1:0] c;
      if (p[3])      c = 2'd3;
      else if (p[2]) c = 2'd0;
      else if (p[1]) c = 2'd1;
      else           c = 2'd2;
      return {v[7:3], c, 1'b0};
   endfunction

   task automatic tick();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic check_int(input string req);
      check(req, int_n, !(|m_pend));
   endtask

   task automatic pulse(input logic [2:0] d, input logic a, input logic b);
      dma = d; l52 = a; lmatch = b;
      tick();
      dma = '0; l52 = 0; lmatch = 0;
      m_pend = m_pend | {a | b, d};
      check_int("R5");
   endtask

   task automatic wreg(input logic [3:0] a, input logic [7:0] d);
      wr = 1; waddr = a; wdata = d;
      tick();
      wr = 0;
      if (a == 4'd5) m_vreg = d;
      if (a == 4'd4) begin
         m_pend = m_pend & ~d[3:0];
         if (d[7]) m_rec = 1'b0;
      end
   endtask

   task automatic read_check(input string req);
      raddr = 4'd4; #1;
      check(req, rdata, {m_rec, 3'b000, m_pend});
      raddr = 4'd5; #1;
      check(req, rdata, m_vreg);
   endtask

   task automatic ack(input string req);
      logic [7:0] e;
      e = exp_vec(m_pend, m_vreg);
      m1_n = 0; iorq_n = 0; #1;
      check("R12", voe, 1'b1);
      check(req, vdata, e);
      tick();
      check("R12", vdata, e);
      if (m_pend[3]) begin
         m_pend[3] = 1'b0; m_rec = 1'b1;
      end else if (m_pend[2:0] != 0 && !m_vreg[0]) begin
         if (m_pend[2]) m_pend[2] = 0;
         else if (m_pend[1]) m_pend[1] = 0;
         else m_pend[0] = 0;
      end
      m1_n = 1; iorq_n = 1; #1;
      check("R12", {voe, vdata}, 9'h0);
      tick();
      check_int("R5");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R6 reset state
      read_check("R6");
      check("R6", int_n, 1'b1);
      // R10 empty acknowledge
      ack("R10");
      read_check("R10");
      // R4 both raster inputs
      pulse(3'b000, 1, 0); read_check("R4");
      wreg(4'd4, 8'h08);   read_check("R11");
      pulse(3'b000, 0, 1); read_check("R4");
      // R9 + R10 double acknowledge
      ack("R9"); read_check("R9");
      m1_n = 0; iorq_n = 0; #1;
      check("R10", vdata, 8'h04);
      tick(); m1_n = 1; iorq_n = 1; tick();
      wreg(4'd4, 8'h80); read_check("R11");
      // R1/R2/R3/R7 auto-clear with base field
      wreg(4'd5, 8'hA8);
      pulse(3'b111, 1, 0);
      ack("R3"); ack("R2"); ack("R2"); ack("R7"); read_check("R7");
      ack("R10");
      // R8 hold mode
      wreg(4'd5, 8'h51);
      pulse(3'b011, 0, 0);
      ack("R8"); ack("R8"); read_check("R8");
      // R11 write 0 ignored, set wins over clear
      wreg(4'd4, 8'h00); read_check("R11");
      dma = 3'b010; wr = 1; waddr = 4'd4; wdata = 8'h02;
      tick(); dma = 0; wr = 0;
      read_check("R11");
      wreg(4'd4, 8'h8F); read_check("R11");
      check_int("R5");
      // random mix
      for (int i = 0; i < 400; i++) begin
         case ($urandom % 6)
            0: pulse(3'($urandom), 0, 0);
            1: pulse(3'b000, 1'($urandom), 1'($urandom));
            2: ack("R1");
            3: wreg(4'd4, 8'($urandom));
            4: wreg(4'd5, 8'($urandom));
            default: read_check("R11");
         endcase
      end
      read_check("R3");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule